// File: doc/BRIEF.md
# Streaming IMA ADPCM Decoder

This block turns a stream of 4-bit adaptive differential codes into 16-bit signed PCM samples. It pulls words from a synchronous input FIFO that has one cycle of read latency, buffers each word, and decodes every code through six clocked arithmetic steps. Each decoded sample is then presented to an output FIFO, and the block waits there as long as that FIFO reports full. One shared datapath does the work. Only the predictor and the step index are kept per channel.

A parameter selects the channel mode. In mono, each input word carries one code in its low nibble. In stereo, one input word carries a code for each of the two channels. The block decodes and writes the low-nibble channel first, then the high-nibble channel, from the same buffered word. It fetches a new word only after the second write has been accepted. Stream headers and mid-stream state reloads are handled elsewhere, so the decoder state starts at zero after reset.

Top module: `adpcm_stream_dec`

## Requirements
- R1: While reset is high, and in the cycles right after it falls, both in_rd_en and out_wr_en are low. The block is idle, and every channel's predictor and step index are zero, so the first decoded sample starts from a predictor of 0 and a step index of 0.
- R2: in_rd_en is high for one cycle at a time. It rises only in the cycle after a cycle in which in_empty was sampled low. The input word is captured from in_data on the clock edge that ends the cycle after in_rd_en.
- R3: In mono mode the code is in_data[3:0]. Bits [15:4] have no effect on any output.
- R4: Each code passes through six sequential decode steps. out_wr_en for the first (or only) sample of a word rises exactly 8 cycles after the cycle in which in_rd_en was high.
- R5: The step table has 89 entries, with s(0)=7 and s(i+1)=min(32767, s(i)+floor(s(i)/16)+floor(s(i)/32)+1). The code's magnitude bits b2,b1,b0 = code[2:0] give the difference d = floor(s/8) + b2*s + b1*floor(s/2) + b0*floor(s/4), where s is the entry at the channel's current step index. Code bit 3 set means the predictor decreases by d; clear means it increases by d. The output sample equals the new predictor.
- R6: After each code, the step index changes by -1 when code[2:0] is 0 to 3, and by +2, +4, +6 or +8 when code[2:0] is 4, 5, 6 or 7. The result is clamped to 0..88.
- R7: The predictor saturates at 32767 and at -32768 instead of wrapping.
- R8: A write is accepted on a clock edge where out_wr_en is high and out_full is low. While out_full is high, out_wr_en stays high and out_data stays unchanged.
- R9: After the write for the last channel of a word is accepted, in_rd_en is high in the next cycle if in_empty was low at that edge. Otherwise the block goes idle. In stereo mode, no read follows the first-channel write.
- R10: In stereo mode, in_data[3:0] is decoded and written first as channel 0, and in_data[7:4] is decoded and written second as channel 1. Each channel has its own predictor and step index. Exactly two writes are accepted between consecutive reads. Bits [15:8] have no effect on any output. The second out_wr_en of a word rises 7 cycles after the first write is accepted.
- R11: out_data stays unchanged for at least 5 clock cycles, counted from the cycle in which out_wr_en rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_rd_en | output | 1 | Read strobe to the input FIFO |
| in_empty | input | 1 | Input FIFO has no word |
| in_data | input | IN_W | Input word, valid the cycle after in_rd_en |
| out_wr_en | output | 1 | Write request to the output FIFO |
| out_full | input | 1 | Output FIFO cannot accept a write |
| out_data | output | PCM_W | Decoded signed PCM sample |

## Verification
The bench samples on falling clock edges and works out each output's due cycle from the edge that caused it. The first write enable of a word must rise 8 cycles after its read strobe. In stereo, the second channel's write enable must rise 7 cycles after the first write is accepted. A read strobe must appear one cycle after the last accepted write whenever the input FIFO held data at that edge. A write held off by a full output FIFO is checked on every stalled cycle for an unchanged request and unchanged data. Each time the sample changes, the bench checks that at least 5 cycles have passed since the previous rise of write enable. Expected samples come from an arithmetic model that runs over code sweeps, saturation runs and pseudo-random words. The model starts from zero state, and the input words carry junk in their unused bits.

// File: rtl/adpcm_pkg.sv
package adpcm_pkg;

   localparam int IDX_LAST = 88;
   localparam int STEP_CNT = IDX_LAST + 1;
   localparam int STEP_W   = 16;
   localparam int IDX_W    = 7;

   typedef logic [STEP_CNT-1:0][STEP_W-1:0] step_tab_t;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_READ,
      ST_LATCH,
      ST_S1,
      ST_S2,
      ST_S3,
      ST_S4,
      ST_S5,
      ST_S6,
      ST_WRITE
   } dec_state_t;

   // geometric step sizes, growth about 9.4 percent per index, clamped
   function automatic step_tab_t build_steps();
      step_tab_t tab;
      int        s;
      s = 7;
      for (int i = 0; i < STEP_CNT; i++) begin
         tab[i] = STEP_W'(s);
         s = s + (s >> 4) + (s >> 5) + 1;
         if (s > 32767) s = 32767;
      end
      return tab;
   endfunction

   function automatic logic signed [4:0] idx_adjust(input logic [2:0] mag);
      logic signed [4:0] adj;
      case (mag)
         3'd4:    adj = 5'sd2;
         3'd5:    adj = 5'sd4;
         3'd6:    adj = 5'sd6;
         3'd7:    adj = 5'sd8;
         default: adj = -5'sd1;
      endcase
      return adj;
   endfunction

endpackage

// File: rtl/adpcm_step_rom.sv
module adpcm_step_rom
   import adpcm_pkg::*;
(
   input  logic [IDX_W-1:0]  idx_i,
   output logic [STEP_W-1:0] step_o
);

   localparam step_tab_t TAB = build_steps();

   always_comb begin
      if (idx_i > IDX_W'(IDX_LAST)) step_o = TAB[IDX_LAST];
      else                          step_o = TAB[idx_i];
   end

endmodule

// File: rtl/adpcm_seq.sv
module adpcm_seq
   import adpcm_pkg::*;
#(
   parameter int NCH  = 1,
   parameter int CH_W = 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_empty,
   input  logic            out_full,
   output dec_state_t      state_o,
   output logic [CH_W-1:0] ch_o,
   output logic            rd_en_o,
   output logic            wr_en_o
);

   localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

   dec_state_t      st_q;
   logic [CH_W-1:0] ch_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= ST_IDLE;
         ch_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE:  if (!in_empty) st_q <= ST_READ;
            ST_READ:  st_q <= ST_LATCH;
            ST_LATCH: begin
               st_q <= ST_S1;
               ch_q <= '0;
            end
            ST_S1:    st_q <= ST_S2;
            ST_S2:    st_q <= ST_S3;
            ST_S3:    st_q <= ST_S4;
            ST_S4:    st_q <= ST_S5;
            ST_S5:    st_q <= ST_S6;
            ST_S6:    st_q <= ST_WRITE;
            ST_WRITE: begin
               if (!out_full) begin
                  if (ch_q != CH_LAST) begin
                     ch_q <= ch_q + 1'b1;
                     st_q <= ST_S1;
                  end else if (!in_empty) begin
                     st_q <= ST_READ;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end
            end
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = st_q;
   assign ch_o    = ch_q;
   assign rd_en_o = (st_q == ST_READ);
   assign wr_en_o = (st_q == ST_WRITE);

endmodule

// File: rtl/adpcm_core.sv
module adpcm_core
   import adpcm_pkg::*;
#(
   parameter int NCH    = 1,
   parameter int CH_W   = 1,
   parameter int CODE_W = 4,
   parameter int USE_W  = 4,
   parameter int PCM_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  dec_state_t        state_i,
   input  logic [CH_W-1:0]   ch_i,
   input  logic [USE_W-1:0]  word_i,
   output logic [PCM_W-1:0]  pcm_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam int DIFF_W = PCM_W + 1;
   localparam int SUM_W  = PCM_W + 3;
   localparam int IW1    = IDX_W + 1;
   localparam logic signed [SUM_W-1:0] PMAX = SUM_W'((1 << (PCM_W - 1)) - 1);
   localparam logic signed [SUM_W-1:0] PMIN = -PMAX - 1;

   logic [USE_W-1:0]        word_q;
   logic [CODE_W-1:0]       code_q;
   logic [CODE_W-1:0]       code_sel;
   logic [STEP_W-1:0]       step_q;
   logic [STEP_W-1:0]       step_w;
   logic [DIFF_W-1:0]       diff_q;
   logic signed [PCM_W-1:0] pnew_q;
   logic [PCM_W-1:0]        out_q;
   logic signed [PCM_W-1:0] sat_w;
   logic signed [PCM_W-1:0] cur_pred;
   logic [IDX_W-1:0]        cur_idx;
   logic [IDX_W-1:0]        idx_next;
   logic signed [IW1-1:0]   idx_sum;
   logic signed [SUM_W-1:0] ext_pred;
   logic signed [SUM_W-1:0] ext_diff;
   logic signed [SUM_W-1:0] sum_w;

   logic signed [PCM_W-1:0] pred_a [NCH];
   logic [IDX_W-1:0]        idx_a  [NCH];

   // per-channel decoder state
   for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic signed [PCM_W-1:0] pred_r;
      logic [IDX_W-1:0]        idx_r;
      always_ff @(posedge clk) begin
         if (rst) begin
            pred_r <= '0;
            idx_r  <= '0;
         end else if (state_i == ST_S6 && ch_i == CH_W'(g)) begin
            pred_r <= pnew_q;
            idx_r  <= idx_next;
         end
      end
      assign pred_a[g] = pred_r;
      assign idx_a[g]  = idx_r;
   end

   // channel selection variant
   if (NCH == 1) begin : g_mono
      assign cur_pred = pred_a[0];
      assign cur_idx  = idx_a[0];
      assign code_sel = word_q[CODE_W-1:0];
   end else begin : g_multi
      assign cur_pred = pred_a[ch_i];
      assign cur_idx  = idx_a[ch_i];
      assign code_sel = word_q[int'(ch_i) * CODE_W +: CODE_W];
   end

   adpcm_step_rom u_rom (
      .idx_i  (cur_idx),
      .step_o (step_w)
   );

   // step index adaptation with clamp
   assign idx_sum = $signed({1'b0, cur_idx}) + IW1'(idx_adjust(code_q[2:0]));
   always_comb begin
      if (idx_sum[IDX_W])                              idx_next = '0;
      else if (idx_sum[IDX_W-1:0] > IDX_W'(IDX_LAST))  idx_next = IDX_W'(IDX_LAST);
      else                                             idx_next = idx_sum[IDX_W-1:0];
   end

   // predictor update with saturation
   assign ext_pred = SUM_W'(cur_pred);
   assign ext_diff = $signed({2'b00, diff_q});
   assign sum_w    = code_q[CODE_W-1] ? (ext_pred - ext_diff) : (ext_pred + ext_diff);
   always_comb begin
      if (sum_w > PMAX)      sat_w = PMAX[PCM_W-1:0];
      else if (sum_w < PMIN) sat_w = PMIN[PCM_W-1:0];
      else                   sat_w = sum_w[PCM_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= '0;
         code_q <= '0;
         step_q <= '0;
         diff_q <= '0;
         pnew_q <= '0;
         out_q  <= '0;
      end else begin
         case (state_i)
            ST_LATCH: word_q <= word_i;
            ST_S1: begin
               code_q <= code_sel;
               step_q <= step_w;
            end
            ST_S2: diff_q <= DIFF_W'(step_q >> 3) + (code_q[2] ? DIFF_W'(step_q) : '0);
            ST_S3: diff_q <= diff_q + (code_q[1] ? DIFF_W'(step_q >> 1) : '0);
            ST_S4: diff_q <= diff_q + (code_q[0] ? DIFF_W'(step_q >> 2) : '0);
            ST_S5: pnew_q <= sat_w;
            ST_S6: out_q  <= pnew_q;
            default: ;
         endcase
      end
   end

   assign pcm_o = out_q;
   assign idx_o = cur_idx;

endmodule

// File: rtl/adpcm_stream_dec.sv
module adpcm_stream_dec
   import adpcm_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int PCM_W  = 16,
   parameter int CODE_W = 4,
   parameter int STEREO = 0
) (
   input  logic             clk,
   input  logic             rst,
   output logic             in_rd_en,
   input  logic             in_empty,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_wr_en,
   input  logic             out_full,
   output logic [PCM_W-1:0] out_data
);

   localparam int NCH   = (STEREO != 0) ? 2 : 1;
   localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int USE_W = NCH * CODE_W;

   if (CODE_W != 4) begin : g_bad_code
      $error("adpcm_stream_dec: CODE_W must be 4");
   end
   if (PCM_W != STEP_W) begin : g_bad_pcm
      $error("adpcm_stream_dec: PCM_W must equal the step table width");
   end
   if (IN_W < USE_W) begin : g_bad_in
      $error("adpcm_stream_dec: IN_W too narrow for the channel codes");
   end

   if (IN_W > USE_W) begin : g_pad
      logic unused_pad;
      assign unused_pad = ^in_data[IN_W-1:USE_W];
   end

   dec_state_t      state;
   logic [CH_W-1:0] ch;
   logic [IDX_W-1:0] cur_idx;

   adpcm_seq #(
      .NCH  (NCH),
      .CH_W (CH_W)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .in_empty (in_empty),
      .out_full (out_full),
      .state_o  (state),
      .ch_o     (ch),
      .rd_en_o  (in_rd_en),
      .wr_en_o  (out_wr_en)
   );

   adpcm_core #(
      .NCH    (NCH),
      .CH_W   (CH_W),
      .CODE_W (CODE_W),
      .USE_W  (USE_W),
      .PCM_W  (PCM_W)
   ) u_core (
      .clk     (clk),
      .rst     (rst),
      .state_i (state),
      .ch_i    (ch),
      .word_i  (in_data[USE_W-1:0]),
      .pcm_o   (out_data),
      .idx_o   (cur_idx)
   );

endmodule

// File: rtl/adpcm_stream_dec_chk.sv
module adpcm_stream_dec_chk
   import adpcm_pkg::*;
#(
   parameter int NCH   = 1,
   parameter int PCM_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             in_rd_en,
   input logic             in_empty,
   input logic             out_wr_en,
   input logic             out_full,
   input logic [PCM_W-1:0] out_data,
   input logic [IDX_W-1:0] cur_idx
);

   logic [7:0] gap_q;
   logic [2:0] wr_cnt_q;
   logic       seen_rd_q;
   logic       wr_d_q;
   logic [2:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q     <= '0;
         wr_cnt_q  <= '0;
         seen_rd_q <= 1'b0;
         wr_d_q    <= 1'b0;
         hold_q    <= '0;
      end else begin
         if (in_rd_en)            gap_q <= 8'd1;
         else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;

         if (in_rd_en)                                       wr_cnt_q <= '0;
         else if (out_wr_en && !out_full && wr_cnt_q != 3'd7) wr_cnt_q <= wr_cnt_q + 3'd1;

         if (in_rd_en) seen_rd_q <= 1'b1;

         wr_d_q <= out_wr_en;
         if (out_wr_en && !wr_d_q)             hold_q <= 3'd1;
         else if (hold_q != 0 && hold_q != 7)  hold_q <= hold_q + 3'd1;
      end
   end

   // R2
   rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      in_rd_en |=> !in_rd_en);

   // R2
   rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
      in_rd_en |-> $past(!in_empty));

   // R4
   first_lat_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(out_wr_en) && wr_cnt_q == 3'd0) |-> gap_q == 8'd8);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_wr_en && out_full) |=> (out_wr_en && $stable(out_data)));

   // R10
   read_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (in_rd_en && seen_rd_q) |-> wr_cnt_q == 3'(NCH));

   // R6
   idx_range_chk: assert property (@(posedge clk) disable iff (rst)
      cur_idx <= IDX_W'(IDX_LAST));

   // R11
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (hold_q != 3'd0 && hold_q < 3'd5) |-> $stable(out_data));

endmodule

bind adpcm_stream_dec adpcm_stream_dec_chk #(
   .NCH   (NCH),
   .PCM_W (PCM_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_rd_en  (in_rd_en),
   .in_empty  (in_empty),
   .out_wr_en (out_wr_en),
   .out_full  (out_full),
   .out_data  (out_data),
   .cur_idx   (cur_idx)
);

// File: tb/adpcm_stream_dec_tb.sv
module adpcm_stream_dec_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NW = 400;
   localparam int NS = 2 * NW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [15:0] words [NW];
   int          exp_m [NW];
   int          exp_s [NS];

   int          wp = 0;
   int          rp_m = 0;
   int          rp_s = 0;
   logic [15:0] rdat_m = '0;
   logic [15:0] rdat_s = '0;
   logic        empty_m, empty_s;
   logic        out_full = 1'b0;

   logic        rd_m, wr_m, rd_s, wr_s;
   logic [15:0] data_m, data_s;

   assign empty_m = (rp_m == wp);
   assign empty_s = (rp_s == wp);

   adpcm_stream_dec #(.STEREO(0)) u_dut (
      .clk(clk), .rst(rst), .in_rd_en(rd_m), .in_empty(empty_m), .in_data(rdat_m),
      .out_wr_en(wr_m), .out_full(out_full), .out_data(data_m)
   );

   adpcm_stream_dec #(.STEREO(1)) u_dut_st (
      .clk(clk), .rst(rst), .in_rd_en(rd_s), .in_empty(empty_s), .in_data(rdat_s),
      .out_wr_en(wr_s), .out_full(out_full), .out_data(data_s)
   );

   // input FIFO models with one cycle read latency
   always @(posedge clk) begin
      if (rd_m) begin
         rdat_m <= words[rp_m];
         rp_m   <= rp_m + 1;
      end
      if (rd_s) begin
         rdat_s <= words[rp_s];
         rp_s   <= rp_s + 1;
      end
   end

   int nchk = 0;
   int nfail = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] x);
      logic [15:0] y;
      y = x ^ (x << 7);
      y = y ^ (y >> 9);
      y = y ^ (y << 8);
      return y;
   endfunction

   function automatic int step_at(input int i);
      int s;
      s = 7;
      for (int k = 0; k < i; k++) begin
         s = s + (s >> 4) + (s >> 5) + 1;
         if (s > 32767) s = 32767;
      end
      return s;
   endfunction

   function automatic int dec_one(input int code, input int pin, input int iin, output int iout);
      int st, d, p, m;
      st = step_at(iin);
      d = st >> 3;
      if ((code & 4) != 0) d += st;
      if ((code & 2) != 0) d += st >> 1;
      if ((code & 1) != 0) d += st >> 2;
      p = ((code & 8) != 0) ? pin - d : pin + d;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      m = code & 7;
      iout = iin + ((m < 4) ? -1 : (m - 3) * 2);
      if (iout < 0) iout = 0;
      if (iout > 88) iout = 88;
      return p;
   endfunction

   function automatic string tag_m(input int i);
      if (i == 0) return "R1";
      if (i < 30) return "R6";
      if (i < 94) return "R5";
      if (i < 294) return "R7";
      return "R3";
   endfunction

   // observation state, index 0 mono, 1 stereo
   int cyc = 0;
   int oc [2];
   int last_rd [2];
   int last_rise [2];
   int wr_since_rd [2];
   bit seen_rd [2];
   bit seen_rise [2];
   bit prev_stall [2];
   bit prev_wr [2];
   bit prev_rd [2];
   bit chk_rd_next [2];
   bit exp_rd [2];
   logic [15:0] prev_data [2];

   task automatic observe(input int k, input logic rd, input logic emp,
                          input logic wr, input logic [15:0] data);
      int nch;
      nch = (k == 0) ? 1 : 2;
      if (chk_rd_next[k]) begin
         check(rd == exp_rd[k], "R9", "read strobe after accepted write", int'(rd), int'(exp_rd[k]));
         chk_rd_next[k] = 1'b0;
      end
      if (rd) begin
         check(!prev_rd[k], "R2", "read strobe lasts one cycle", int'(prev_rd[k]), 0);
         if (seen_rd[k])
            check(wr_since_rd[k] == nch, (k == 0) ? "R2" : "R10",
                  "writes between reads", wr_since_rd[k], nch);
         wr_since_rd[k] = 0;
         seen_rd[k] = 1'b1;
         last_rd[k] = cyc;
      end
      if (prev_stall[k])
         check(wr && data == prev_data[k], "R8", "held write under full",
               int'(wr) * 65536 + int'(data), 65536 + int'(prev_data[k]));
      if (data != prev_data[k] && seen_rise[k])
         check(cyc - last_rise[k] >= 5, "R11", "cycles output held", cyc - last_rise[k], 5);
      if (wr && !prev_wr[k]) begin
         if (wr_since_rd[k] == 0)
            check(cyc - last_rd[k] == 8, "R4", "read to write latency", cyc - last_rd[k], 8);
         last_rise[k] = cyc;
         seen_rise[k] = 1'b1;
      end
      if (wr && !out_full) begin
         if (k == 0) begin
            if (oc[0] < NW)
               check(int'($signed(data)) == exp_m[oc[0]], tag_m(oc[0]), "mono sample",
                     int'($signed(data)), exp_m[oc[0]]);
            else
               check(1'b0, "R9", "extra mono write", oc[0], NW);
         end else begin
            if (oc[1] < NS)
               check(int'($signed(data)) == exp_s[oc[1]], "R10", "stereo sample",
                     int'($signed(data)), exp_s[oc[1]]);
            else
               check(1'b0, "R10", "extra stereo write", oc[1], NS);
         end
         oc[k]++;
         wr_since_rd[k]++;
         chk_rd_next[k] = 1'b1;
         exp_rd[k] = ((oc[k] % nch) == 0) ? !emp : 1'b0;
      end
      prev_stall[k] = wr && out_full;
      prev_data[k]  = data;
      prev_wr[k]    = wr;
      prev_rd[k]    = rd;
   endtask

   initial begin
      for (int k = 0; k < 2; k++) begin
         oc[k] = 0; last_rd[k] = 0; last_rise[k] = 0; wr_since_rd[k] = 0;
         seen_rd[k] = 0; seen_rise[k] = 0; prev_stall[k] = 0; prev_wr[k] = 0;
         prev_rd[k] = 0; chk_rd_next[k] = 0; exp_rd[k] = 0; prev_data[k] = '0;
      end
   end

   always @(negedge clk) begin
      if (!rst) begin
         cyc++;
         observe(0, rd_m, empty_m, wr_m, data_m);
         observe(1, rd_s, empty_s, wr_s, data_s);
      end
   end

   // output full pattern, changed just after each rising edge
   initial begin
      logic [15:0] f;
      f = 16'h1D2B;
      @(negedge rst);
      forever begin
         @(posedge clk);
         #1;
         f = nxt(f);
         out_full = (f[1:0] == 2'b00);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog expired with %0d and %0d samples", oc[0], oc[1]);
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      int pm, im, p0, i0, p1, i1, ni, c;
      r = 16'hACE1;
      for (int i = 0; i < NW; i++) begin
         logic [3:0] lo, hi;
         r = nxt(r);
         if (i < 30) begin
            lo = 4'h0; hi = 4'h0;
         end else if (i < 94) begin
            lo = 4'((i - 30) % 16); hi = 4'(15 - (i - 30) % 16);
         end else if (i < 194) begin
            lo = 4'h7; hi = 4'h7;
         end else if (i < 294) begin
            lo = 4'hF; hi = 4'hF;
         end else begin
            lo = r[3:0]; hi = r[7:4];
         end
         // R3 R10: upper byte always carries junk
         words[i] = {r[15:8], hi, lo};
      end
      pm = 0; im = 0; p0 = 0; i0 = 0; p1 = 0; i1 = 0;
      for (int i = 0; i < NW; i++) begin
         c = int'(words[i][3:0]);
         exp_m[i] = dec_one(c, pm, im, ni);
         pm = exp_m[i]; im = ni;
         exp_s[2*i] = dec_one(c, p0, i0, ni);
         p0 = exp_s[2*i]; i0 = ni;
         c = int'(words[i][7:4]);
         exp_s[2*i+1] = dec_one(c, p1, i1, ni);
         p1 = exp_s[2*i+1]; i1 = ni;
      end

      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      // R1: outputs quiet after reset while the input is empty
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         check(!rd_m && !rd_s, "R1", "read strobe while empty", int'(rd_m | rd_s), 0);
         check(!wr_m && !wr_s, "R1", "write enable after reset", int'(wr_m | wr_s), 0);
      end

      for (int i = 0; i < NW; i++) begin
         if (i < 50) repeat (12) @(posedge clk);
         @(posedge clk);
         #1 wp = wp + 1;
      end

      while (oc[0] < NW || oc[1] < NS) @(posedge clk);
      repeat (30) @(posedge clk);
      @(negedge clk);
      check(rp_m == NW, "R2", "mono words read", rp_m, NW);
      check(rp_s == NW, "R10", "stereo words read", rp_s, NW);
      check(oc[0] == NW, "R9", "mono samples written", oc[0], NW);
      check(oc[1] == NS, "R10", "stereo samples written", oc[1], NS);
      check(!wr_m && !wr_s && !rd_m && !rd_s, "R9", "idle after drain",
            int'(wr_m | wr_s | rd_m | rd_s), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

endmodule